// File: doc/BRIEF.md
# Colour Palette Lookup with Register Programming

This block holds a 256-entry colour table, each entry made of separate 8-bit red, green and blue channels. A host programs the table through a four-word register window. It first writes a starting entry number to the pointer word. It then writes colour bytes to the colour word, three writes per entry. Each colour byte is carried in the most significant byte of the 32-bit write. After the third byte the pointer moves on to the next entry, so a whole table can be streamed with a single pointer write. The read side of the window exists, but every read returns zero.

A separate lookup port turns an 8-bit pixel code into a 24-bit colour one clock later. The lookup port is independent of the host side and reads whatever the table holds at that moment. A channel that has just been written can therefore be seen before the rest of its entry is complete.

The channel sequencer is a three-state machine. `PH_RED` is the reset state and is also entered on every pointer write. A colour write takes `PH_RED` to `PH_GREEN` (red stored) and `PH_GREEN` to `PH_BLUE` (green stored). A colour write in `PH_BLUE` stores blue, advances the pointer and returns to `PH_RED`. Writes to the two unused words leave the state unchanged.

Top module: `pal_dac`

## Requirements
- R1: A write to word 0 (`wr_word` = 0) loads the entry pointer from `wr_data[31:24]` and puts the sequencer in `PH_RED`.
- R2: Writes to word 1 take the colour byte from `wr_data[31:24]` and ignore bits 23:0. Starting from `PH_RED`, successive writes store red, then green, then blue at the pointed entry.
- R3: The colour write made in `PH_BLUE` increments the pointer modulo 256, so entry 255 is followed by entry 0, and returns the sequencer to `PH_RED`.
- R4: Writes to words 2 and 3 change neither the table, the pointer nor the sequencer state.
- R5: `rd_data` is zero for every read, whatever word is addressed.
- R6: After reset, entries 0 to 254 read as 0x000000 and entry 255 reads as 0xFFFFFF. The pointer is 0 and the sequencer is in `PH_RED`.
- R7: `lk_rgb` presents the entry addressed by `lk_idx` one clock after `lk_idx` is sampled, packed as red in bits 23:16, green in 15:8 and blue in 7:0.
- R8: Each channel write is visible on the lookup port from the clock after it is taken, even when the entry's remaining channels are still unwritten.
- R9: `wr_strb` has no effect. A write with any strobe pattern acts as a full 32-bit write.
- R10: A pointer write in the middle of a sequence abandons that sequence. The next colour write stores red at the new entry, and the channels already written to the old entry keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle it is high |
| wr_word | input | 2 | Word offset of the write inside the window |
| wr_data | input | 32 | Write data; the byte of interest is bits 31:24 |
| wr_strb | input | 4 | Byte strobes, accepted and disregarded |
| rd_en | input | 1 | Host read strobe |
| rd_word | input | 2 | Word offset of the read |
| rd_data | output | 32 | Read data, always zero |
| lk_idx | input | 8 | Pixel code to look up |
| lk_rgb | output | 24 | Colour for the code sampled on the previous clock |

## Verification
The assertions assume that `wr_word` and `wr_data` are known whenever `wr_en` is high. They also assume that the lookup input holds still through any cycle in which the checker compares successive colours. The bench meets both assumptions by driving every input on the falling edge and returning `wr_en` to zero between writes. It keeps `lk_idx` constant while reset is held, and it runs each scenario as a short burst of writes followed by lookups, with the port idle in between.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int unsigned PAL_CH_W   = 8;
    localparam int unsigned PAL_IDX_W  = 8;
    localparam int unsigned PAL_DATA_W = 32;
    localparam int unsigned PAL_WORD_W = 2;

    // Word offsets that have an effect; all others are ignored.
    localparam logic [PAL_WORD_W-1:0] WORD_POINTER = 2'd0;
    localparam logic [PAL_WORD_W-1:0] WORD_COLOUR  = 2'd1;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } pal_phase_e;

    typedef struct packed {
        logic [PAL_CH_W-1:0] red;
        logic [PAL_CH_W-1:0] green;
        logic [PAL_CH_W-1:0] blue;
    } pal_rgb_t;

endpackage

// File: rtl/pal_regdec.sv
module pal_regdec
    import pal_pkg::*;
#(
    parameter int unsigned DATA_W = PAL_DATA_W,
    parameter int unsigned WORD_W = PAL_WORD_W,
    parameter int unsigned IDX_W  = PAL_IDX_W,
    parameter int unsigned CH_W   = PAL_CH_W
) (
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ptr_load,
    output logic              col_write,
    output logic [IDX_W-1:0]  ptr_value,
    output logic [CH_W-1:0]   col_value
);

    localparam int unsigned TOP = DATA_W - 1;

    always_comb begin
        ptr_load  = 1'b0;
        col_write = 1'b0;
        if (wr_en) begin
            unique case (wr_word)
                WORD_POINTER: ptr_load  = 1'b1;
                WORD_COLOUR:  col_write = 1'b1;
                default: begin
                    ptr_load  = 1'b0;
                    col_write = 1'b0;
                end
            endcase
        end
    end

    assign ptr_value = wr_data[TOP -: IDX_W];
    assign col_value = wr_data[TOP -: CH_W];

endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = PAL_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_load,
    input  logic             col_write,
    input  logic [IDX_W-1:0] ptr_value,
    output pal_phase_e       phase,
    output logic [IDX_W-1:0] cur_idx,
    output logic             we_red,
    output logic             we_green,
    output logic             we_blue
);

    pal_phase_e       phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // Next state and pointer
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        if (ptr_load) begin
            phase_d = PH_RED;
            idx_d   = ptr_value;
        end else if (col_write) begin
            unique case (phase_q)
                PH_RED:   phase_d = PH_GREEN;
                PH_GREEN: phase_d = PH_BLUE;
                PH_BLUE: begin
                    phase_d = PH_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default:  phase_d = PH_RED;
            endcase
        end
    end

    // Outputs: channel write enables
    always_comb begin
        we_red   = 1'b0;
        we_green = 1'b0;
        we_blue  = 1'b0;
        if (col_write && !ptr_load) begin
            unique case (phase_q)
                PH_RED:   we_red   = 1'b1;
                PH_GREEN: we_green = 1'b1;
                PH_BLUE:  we_blue  = 1'b1;
                default: begin
                    we_red   = 1'b0;
                    we_green = 1'b0;
                    we_blue  = 1'b0;
                end
            endcase
        end
    end

    assign phase   = phase_q;
    assign cur_idx = idx_q;

endmodule

// File: rtl/pal_table.sv
module pal_table
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = PAL_IDX_W,
    parameter int unsigned CH_W  = PAL_CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CH_W-1:0]   wr_byte,
    input  logic              we_red,
    input  logic              we_green,
    input  logic              we_blue,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [3*CH_W-1:0] lk_rgb
);

    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned LAST    = ENTRIES - 1;

    logic [CH_W-1:0] red_mem   [ENTRIES];
    logic [CH_W-1:0] green_mem [ENTRIES];
    logic [CH_W-1:0] blue_mem  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam logic [CH_W-1:0] INIT = (e == LAST) ? {CH_W{1'b1}} : {CH_W{1'b0}};
        logic hit;
        assign hit = (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                red_mem[e]   <= INIT;
                green_mem[e] <= INIT;
                blue_mem[e]  <= INIT;
            end else begin
                if (hit && we_red)   red_mem[e]   <= wr_byte;
                if (hit && we_green) green_mem[e] <= wr_byte;
                if (hit && we_blue)  blue_mem[e]  <= wr_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rgb <= '0;
        end else begin
            lk_rgb <= {red_mem[lk_idx], green_mem[lk_idx], blue_mem[lk_idx]};
        end
    end

endmodule

// File: rtl/pal_dac.sv
module pal_dac
    import pal_pkg::*;
#(
    parameter int unsigned DATA_W = PAL_DATA_W,
    parameter int unsigned WORD_W = PAL_WORD_W,
    parameter int unsigned IDX_W  = PAL_IDX_W,
    parameter int unsigned CH_W   = PAL_CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_word,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_strb,
    input  logic                rd_en,
    input  logic [WORD_W-1:0]   rd_word,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [3*CH_W-1:0]   lk_rgb
);

    localparam int unsigned LOW_W = DATA_W - CH_W;

    logic             ptr_load, col_write;
    logic [IDX_W-1:0] ptr_value, cur_idx;
    logic [CH_W-1:0]  col_value;
    logic             we_red, we_green, we_blue;
    pal_phase_e       phase;

    pal_regdec #(
        .DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .CH_W(CH_W)
    ) u_dec (
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .wr_data   (wr_data),
        .ptr_load  (ptr_load),
        .col_write (col_write),
        .ptr_value (ptr_value),
        .col_value (col_value)
    );

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (ptr_load),
        .col_write (col_write),
        .ptr_value (ptr_value),
        .phase     (phase),
        .cur_idx   (cur_idx),
        .we_red    (we_red),
        .we_green  (we_green),
        .we_blue   (we_blue)
    );

    pal_table #(.IDX_W(IDX_W), .CH_W(CH_W)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_idx   (cur_idx),
        .wr_byte  (col_value),
        .we_red   (we_red),
        .we_green (we_green),
        .we_blue  (we_blue),
        .lk_idx   (lk_idx),
        .lk_rgb   (lk_rgb)
    );

    // The read side of the window carries no state.
    assign rd_data = '0;

    logic unused_inputs;
    assign unused_inputs = ^{wr_strb, rd_en, rd_word, wr_data[LOW_W-1:0]};

endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
    import pal_pkg::*;
#(
    parameter int unsigned WORD_W = PAL_WORD_W,
    parameter int unsigned DATA_W = PAL_DATA_W,
    parameter int unsigned IDX_W  = PAL_IDX_W,
    parameter int unsigned CH_W   = PAL_CH_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_word,
    input logic [DATA_W-1:0] wr_data,
    input logic [IDX_W-1:0]  lk_idx,
    input logic [3*CH_W-1:0] lk_rgb,
    input logic [IDX_W-1:0]  cur_idx,
    input pal_phase_e        phase
);

    logic ptr_wr, col_wr, idle_wr;
    assign ptr_wr  = wr_en && (wr_word == 2'd0);
    assign col_wr  = wr_en && (wr_word == 2'd1);
    assign idle_wr = wr_en && (wr_word >= 2'd2);

    assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (cur_idx == $past(wr_data[DATA_W-1 -: IDX_W])) && (phase == PH_RED));

    assert_red_to_green_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && phase == PH_RED) |=> (phase == PH_GREEN) && $stable(cur_idx));

    assert_green_to_blue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && phase == PH_GREEN) |=> (phase == PH_BLUE) && $stable(cur_idx));

    assert_blue_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && phase == PH_BLUE) |=> (phase == PH_RED) && (cur_idx == $past(cur_idx) + 1'b1));

    assert_ignored_words_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idle_wr |=> $stable(cur_idx) && $stable(phase));

    assert_reset_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cur_idx == '0) && (phase == PH_RED));

    assert_lookup_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && !wr_en && $stable(lk_idx)) |=> $stable(lk_rgb));

endmodule

bind pal_dac pal_dac_chk #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CH_W(CH_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .wr_data (wr_data),
    .lk_idx  (lk_idx),
    .lk_rgb  (lk_rgb),
    .cur_idx (cur_idx),
    .phase   (phase)
);

// File: tb/pal_dac_bench.sv
module pal_dac_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_word = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = 4'hF;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_word = '0;
    logic [31:0] rd_data;
    logic [7:0]  lk_idx = '0;
    logic [23:0] lk_rgb;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model built from the requirements
    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];
    logic [7:0] m_idx;
    int         m_ph;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_dac u_pal_dac (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_data(wr_data), .wr_strb(wr_strb), .rd_en(rd_en),
        .rd_word(rd_word), .rd_data(rd_data), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%06h expected 0x%06h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = (i == 255) ? 8'hFF : 8'h00;
            m_g[i] = (i == 255) ? 8'hFF : 8'h00;
            m_b[i] = (i == 255) ? 8'hFF : 8'h00;
        end
        m_idx = 8'h00;
        m_ph  = 0;
    endtask

    task automatic host_write(input logic [1:0] w, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_word = w; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = 4'hF;
        if (w == 2'd0) begin
            m_idx = d[31:24];
            m_ph  = 0;
        end else if (w == 2'd1) begin
            case (m_ph)
                0: m_r[m_idx] = d[31:24];
                1: m_g[m_idx] = d[31:24];
                default: m_b[m_idx] = d[31:24];
            endcase
            if (m_ph == 2) begin
                m_ph  = 0;
                m_idx = m_idx + 8'd1;
            end else begin
                m_ph = m_ph + 1;
            end
        end
    endtask

    task automatic look(input string req, input logic [7:0] i);
        @(negedge clk);
        lk_idx = i;
        @(negedge clk);
        check(req, {8'h00, lk_rgb}, {8'h00, m_r[i], m_g[i], m_b[i]});
    endtask

    task automatic t_reset_state();
        look("R6", 8'd0);
        look("R6", 8'd7);
        look("R6", 8'd254);
        look("R6", 8'd255);
        // R6: pointer 0 and red phase -> first colour write hits red of entry 0
        host_write(2'd1, 32'h5A00_0000, 4'hF);
        look("R6", 8'd0);
    endtask

    task automatic t_full_sequence();
        host_write(2'd0, 32'h10FF_FFFF, 4'hF);          // R1
        host_write(2'd1, 32'hAA12_3456, 4'hF);          // R2 low bits ignored
        host_write(2'd1, 32'hBB00_0000, 4'hF);
        host_write(2'd1, 32'hCCFF_FFFF, 4'hF);
        look("R2", 8'h10);
        host_write(2'd1, 32'h7700_0000, 4'hF);          // R3 pointer moved to 0x11
        look("R3", 8'h11);
        look("R1", 8'h10);
    endtask

    task automatic t_partial_visibility();
        host_write(2'd0, 32'h2000_0000, 4'hF);
        host_write(2'd1, 32'h5500_0000, 4'hF);
        look("R8", 8'h20);
        host_write(2'd1, 32'h6600_0000, 4'hF);
        look("R8", 8'h20);
        host_write(2'd1, 32'h9900_0000, 4'hF);
        look("R8", 8'h20);
    endtask

    task automatic t_restart();
        host_write(2'd0, 32'h3000_0000, 4'hF);
        host_write(2'd1, 32'h1100_0000, 4'hF);
        host_write(2'd1, 32'h1200_0000, 4'hF);
        host_write(2'd0, 32'h3100_0000, 4'hF);          // R10
        host_write(2'd1, 32'h2200_0000, 4'hF);
        look("R10", 8'h30);
        look("R10", 8'h31);
    endtask

    task automatic t_wrap();
        host_write(2'd0, 32'hFF00_0000, 4'hF);
        host_write(2'd1, 32'h0100_0000, 4'hF);
        host_write(2'd1, 32'h0200_0000, 4'hF);
        host_write(2'd1, 32'h0300_0000, 4'hF);
        look("R3", 8'hFF);
        host_write(2'd1, 32'h4400_0000, 4'hF);          // lands on entry 0
        look("R3", 8'h00);
    endtask

    task automatic t_ignored_words();
        host_write(2'd0, 32'h4000_0000, 4'hF);
        host_write(2'd2, 32'h4100_0000, 4'hF);          // R4
        host_write(2'd3, 32'hEE00_0000, 4'hF);
        host_write(2'd1, 32'h8800_0000, 4'hF);
        look("R4", 8'h40);
        look("R4", 8'h41);
        look("R4", 8'hEE);
    endtask

    task automatic t_strobes();
        host_write(2'd0, 32'h5000_0000, 4'b0001);       // R9
        host_write(2'd1, 32'h3300_0000, 4'b0001);
        host_write(2'd1, 32'h4400_0000, 4'b0010);
        host_write(2'd1, 32'h5500_0000, 4'b0000);
        look("R9", 8'h50);
    endtask

    task automatic t_reads();
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            rd_en = 1'b1; rd_word = 2'(w);
            #1;
            check("R5", rd_data, 32'h0);
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_lookup_latency();
        // R7: value changes one clock after the index is sampled
        @(negedge clk);
        lk_idx = 8'h10;
        @(negedge clk);
        lk_idx = 8'h50;
        check("R7", {8'h00, lk_rgb}, {8'h00, m_r[8'h10], m_g[8'h10], m_b[8'h10]});
        @(negedge clk);
        check("R7", {8'h00, lk_rgb}, {8'h00, m_r[8'h50], m_g[8'h50], m_b[8'h50]});
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_full_sequence();
        t_partial_visibility();
        t_restart();
        t_wrap();
        t_ignored_words();
        t_strobes();
        t_reads();
        t_lookup_latency();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule